// File: doc/BRIEF.md
# Time-in-Range Evaluation Monitor

This block scores how well a run of sampled operating parameters (for example core temperature and core clock frequency) keeps to a target residency profile. Each parameter has a fixed number of value ranges. Over an observation window of a programmed number of samples, the block counts how often each parameter lands in each range. When the window closes, it divides each range's count by a programmed desired count. Because both shares are taken over the same window, this quotient equals the ratio of actual share to desired share, and a value of 1.0 means the target was met.

The ratios of one parameter are combined by a weighted sum into a per-parameter score. With weights that add to 1.0, the ideal score is 1.0. The scores of all parameters are then added into one index, whose ideal value is the number of parameters monitored. Every parameter goes through identical logic, so changing the parameter count changes only the array sizes and leaves the scoring arithmetic as it is.

A typical use is to run a thermal controller for a window, read the index and the per-range ratios when `done_o` pulses, and compare controller settings. Choosing range bounds and tuning the controller are left to the surrounding system.

Top module: `tir_eval_monitor`

## Requirements
- R1: While `rst` is high, and after it is released, `done_o` is 0 and every ratio, error, score, index and unclassified output is 0 until the first window completes.
- R2: A sample of parameter p counts in range r when lo ≤ value ≤ hi (both bounds inclusive). When ranges overlap, the lowest-numbered range that matches takes the sample. Range k = p·R_NUM + r occupies slice k of every per-range bus.
- R3: A sample of parameter p that matches none of its ranges is counted in that parameter's unclassified counter. The counter is reported on `unclass_o` slice p when the window completes.
- R4: The window closes on the accepted sample whose number equals `win_len_i`, and that sample is counted. A `win_len_i` of 0 behaves as 1.
- R5: Each ratio is unsigned Q8.8 and equals min(floor(count·256 / desired), 65535).
- R6: A desired count of 0 gives a ratio of 65535 and sets that range's `err_o` bit. A nonzero desired count clears the bit.
- R7: Score p equals floor(Σr ratio·weight / 256), where each weight is unsigned Q1.8 (256 = 1.0).
- R8: `index_o` equals the sum of all parameter scores.
- R9: `done_o` is a single-cycle pulse. It rises 1 + Σk c_k clock edges after the closing sample's edge, where c_k is 1 for a zero desired count and CNT_W+FRAC+1 (25 by default) otherwise. All result outputs change only on that edge and hold until the next pulse.
- R10: Samples that arrive between the closing sample and the `done_o` pulse are ignored. All counters are zero when `done_o` is high, and the next window starts with the next strobed sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 1 | Sample strobe |
| vals_i | input | P_NUM*VAL_W | Parameter values, parameter p in slice p |
| lo_i | input | P_NUM*R_NUM*VAL_W | Inclusive lower bound per range |
| hi_i | input | P_NUM*R_NUM*VAL_W | Inclusive upper bound per range |
| win_len_i | input | CNT_W | Window length in samples |
| des_i | input | P_NUM*R_NUM*CNT_W | Desired sample count per range |
| wgt_i | input | P_NUM*R_NUM*(FRAC+1) | Range weight, Q1.8 |
| done_o | output | 1 | Result-ready pulse |
| ratio_o | output | P_NUM*R_NUM*RATIO_W | Per-range ratio, Q8.8 |
| err_o | output | P_NUM*R_NUM | Zero-desired-count flag per range |
| psum_o | output | P_NUM*PSUM_W | Per-parameter weighted score, Q.8 |
| index_o | output | IDX_W | Overall index, Q.8 |
| unclass_o | output | P_NUM*CNT_W | Unclassified sample count per parameter |

## Verification
Results fall due a fixed number of edges after the closing sample. That number depends only on how many desired counts are zero: one edge for each such range, 25 edges for each other range, and one final edge. The bench counts edges from the closing sample to the `done_o` pulse and compares that count with the same sum, which it works out from the desired counts it programmed. It reads every result at the falling edge in the cycle `done_o` is high. It samples once more a cycle later to confirm that the pulse has dropped. Samples strobed during the evaluation gap are left out of the bench's model, so any of them reaching the counters shows up in the next window's ratios.

// File: rtl/tir_pkg.sv
package tir_pkg;
  typedef enum logic [1:0] {
    ST_ACC  = 2'd0,
    ST_LOAD = 2'd1,
    ST_DIV  = 2'd2,
    ST_FIN  = 2'd3
  } tir_state_e;
endpackage

// File: rtl/tir_classifier.sv
module tir_classifier #(
  parameter int R_NUM = 3,
  parameter int VAL_W = 8
) (
  input  logic [VAL_W-1:0]       val_i,
  input  logic [R_NUM*VAL_W-1:0] lo_i,
  input  logic [R_NUM*VAL_W-1:0] hi_i,
  output logic [R_NUM-1:0]       hit_o,
  output logic                   miss_o
);
  logic found;

  always_comb begin
    hit_o = '0;
    found = 1'b0;
    for (int r = 0; r < R_NUM; r++) begin
      if (!found && (val_i >= lo_i[r*VAL_W +: VAL_W]) && (val_i <= hi_i[r*VAL_W +: VAL_W])) begin
        hit_o[r] = 1'b1;
        found    = 1'b1;
      end
    end
    miss_o = !found;
  end
endmodule

// File: rtl/tir_counters.sv
module tir_counters #(
  parameter int P_NUM = 2,
  parameter int R_NUM = 3,
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr_i,
  input  logic                         take_i,
  input  logic [P_NUM*R_NUM-1:0]       hit_i,
  input  logic [P_NUM-1:0]             miss_i,
  output logic [P_NUM*R_NUM*CNT_W-1:0] cnt_o,
  output logic [P_NUM*CNT_W-1:0]       ucnt_o
);
  localparam int K_TOT = P_NUM * R_NUM;

  for (genvar k = 0; k < K_TOT; k++) begin : g_rng
    logic [CNT_W-1:0] c;
    always_ff @(posedge clk) begin
      if (rst || clr_i)          c <= '0;
      else if (take_i && hit_i[k]) c <= c + 1'b1;
    end
    assign cnt_o[k*CNT_W +: CNT_W] = c;
  end

  for (genvar p = 0; p < P_NUM; p++) begin : g_miss
    logic [CNT_W-1:0] u;
    always_ff @(posedge clk) begin
      if (rst || clr_i)           u <= '0;
      else if (take_i && miss_i[p]) u <= u + 1'b1;
    end
    assign ucnt_o[p*CNT_W +: CNT_W] = u;
  end
endmodule

// File: rtl/tir_divider.sv
module tir_divider #(
  parameter int CNT_W = 16,
  parameter int FRAC  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [CNT_W-1:0]      num_i,
  input  logic [CNT_W-1:0]      den_i,
  output logic                  last_o,
  output logic [CNT_W+FRAC-1:0] quo_o
);
  localparam int NUM_W = CNT_W + FRAC;
  localparam int IT_W  = $clog2(NUM_W + 1);

  logic               busy;
  logic [IT_W-1:0]    it;
  logic [CNT_W:0]     rem;
  logic [NUM_W-1:0]   acc;
  logic [CNT_W-1:0]   den;
  logic [CNT_W+1:0]   rem_w;
  logic               ge;

  assign rem_w  = {rem, acc[NUM_W-1]};
  assign ge     = rem_w >= {2'b00, den};
  assign last_o = busy && (it == IT_W'(NUM_W - 1));
  assign quo_o  = {acc[NUM_W-2:0], ge};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      it   <= '0;
      rem  <= '0;
      acc  <= '0;
      den  <= '0;
    end else if (start_i) begin
      busy <= 1'b1;
      it   <= '0;
      rem  <= '0;
      acc  <= {num_i, {FRAC{1'b0}}};
      den  <= den_i;
    end else if (busy) begin
      rem  <= ge ? (CNT_W+1)'(rem_w - {2'b00, den}) : (CNT_W+1)'(rem_w);
      acc  <= {acc[NUM_W-2:0], ge};
      it   <= it + 1'b1;
      if (last_o) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/tir_summer.sv
module tir_summer #(
  parameter int P_NUM   = 2,
  parameter int R_NUM   = 3,
  parameter int RATIO_W = 16,
  parameter int FRAC    = 8,
  parameter int PSUM_W  = 19,
  parameter int IDX_W   = 20
) (
  input  logic [P_NUM*R_NUM*RATIO_W-1:0]  ratio_i,
  input  logic [P_NUM*R_NUM*(FRAC+1)-1:0] wgt_i,
  output logic [P_NUM*PSUM_W-1:0]         psum_o,
  output logic [IDX_W-1:0]                index_o
);
  localparam int WGT_W = FRAC + 1;
  localparam int ACC_W = PSUM_W + FRAC;

  for (genvar p = 0; p < P_NUM; p++) begin : g_par
    logic [ACC_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int r = 0; r < R_NUM; r++) begin
        acc = acc + ACC_W'(ratio_i[(p*R_NUM+r)*RATIO_W +: RATIO_W])
                  * ACC_W'(wgt_i[(p*R_NUM+r)*WGT_W +: WGT_W]);
      end
    end
    assign psum_o[p*PSUM_W +: PSUM_W] = acc[ACC_W-1:FRAC];
  end

  always_comb begin
    index_o = '0;
    for (int p = 0; p < P_NUM; p++) begin
      index_o = index_o + IDX_W'(psum_o[p*PSUM_W +: PSUM_W]);
    end
  end
endmodule

// File: rtl/tir_eval_monitor.sv
module tir_eval_monitor
  import tir_pkg::*;
#(
  parameter int P_NUM   = 2,
  parameter int R_NUM   = 3,
  parameter int VAL_W   = 8,
  parameter int CNT_W   = 16,
  parameter int FRAC    = 8,
  parameter int RATIO_W = 16,
  parameter int PSUM_W  = RATIO_W + FRAC + 1 + $clog2(R_NUM) - FRAC,
  parameter int IDX_W   = PSUM_W + $clog2(P_NUM)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            smp_i,
  input  logic [P_NUM*VAL_W-1:0]          vals_i,
  input  logic [P_NUM*R_NUM*VAL_W-1:0]    lo_i,
  input  logic [P_NUM*R_NUM*VAL_W-1:0]    hi_i,
  input  logic [CNT_W-1:0]                win_len_i,
  input  logic [P_NUM*R_NUM*CNT_W-1:0]    des_i,
  input  logic [P_NUM*R_NUM*(FRAC+1)-1:0] wgt_i,
  output logic                            done_o,
  output logic [P_NUM*R_NUM*RATIO_W-1:0]  ratio_o,
  output logic [P_NUM*R_NUM-1:0]          err_o,
  output logic [P_NUM*PSUM_W-1:0]         psum_o,
  output logic [IDX_W-1:0]                index_o,
  output logic [P_NUM*CNT_W-1:0]          unclass_o
);
  localparam int K_TOT = P_NUM * R_NUM;
  localparam int K_W   = (K_TOT > 1) ? $clog2(K_TOT) : 1;
  localparam int NUM_W = CNT_W + FRAC;

  tir_state_e            st;
  logic [K_W-1:0]        k;
  logic [CNT_W-1:0]      win_cnt;
  logic                  take, close_w, clr;
  logic [K_TOT-1:0]      hit_all;
  logic [P_NUM-1:0]      miss_all;
  logic [K_TOT*CNT_W-1:0] cnt_all;
  logic [P_NUM*CNT_W-1:0] ucnt_all;
  logic [CNT_W-1:0]      cur_cnt, cur_des;
  logic                  des_zero, div_start, div_last, k_last;
  logic [NUM_W-1:0]      quo;
  logic [RATIO_W-1:0]    quo_sat;
  logic [RATIO_W-1:0]    ratio_q [K_TOT];
  logic [K_TOT-1:0]      err_q;
  logic [K_TOT*RATIO_W-1:0] ratio_flat;
  logic [P_NUM*PSUM_W-1:0]  psum_c;
  logic [IDX_W-1:0]         index_c;

  // classification, one per parameter
  for (genvar p = 0; p < P_NUM; p++) begin : g_cls
    tir_classifier #(.R_NUM(R_NUM), .VAL_W(VAL_W)) u_cls (
      .val_i  (vals_i[p*VAL_W +: VAL_W]),
      .lo_i   (lo_i[p*R_NUM*VAL_W +: R_NUM*VAL_W]),
      .hi_i   (hi_i[p*R_NUM*VAL_W +: R_NUM*VAL_W]),
      .hit_o  (hit_all[p*R_NUM +: R_NUM]),
      .miss_o (miss_all[p])
    );
  end

  assign take    = (st == ST_ACC) && smp_i;
  assign close_w = take && (({1'b0, win_cnt} + 1'b1) >= {1'b0, win_len_i});
  assign clr     = (st == ST_FIN);

  tir_counters #(.P_NUM(P_NUM), .R_NUM(R_NUM), .CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .take_i (take),
    .hit_i  (hit_all),
    .miss_i (miss_all),
    .cnt_o  (cnt_all),
    .ucnt_o (ucnt_all)
  );

  assign cur_cnt   = cnt_all[k*CNT_W +: CNT_W];
  assign cur_des   = des_i[k*CNT_W +: CNT_W];
  assign des_zero  = (cur_des == '0);
  assign div_start = (st == ST_LOAD) && !des_zero;
  assign k_last    = (k == K_W'(K_TOT - 1));

  tir_divider #(.CNT_W(CNT_W), .FRAC(FRAC)) u_div (
    .clk     (clk),
    .rst     (rst),
    .start_i (div_start),
    .num_i   (cur_cnt),
    .den_i   (cur_des),
    .last_o  (div_last),
    .quo_o   (quo)
  );

  assign quo_sat = (quo[NUM_W-1:RATIO_W] != '0) ? {RATIO_W{1'b1}} : quo[RATIO_W-1:0];

  // sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_ACC;
      k       <= '0;
      win_cnt <= '0;
    end else begin
      case (st)
        ST_ACC: begin
          if (take) win_cnt <= win_cnt + 1'b1;
          if (close_w) begin
            st <= ST_LOAD;
            k  <= '0;
          end
        end
        ST_LOAD: begin
          if (!des_zero)   st <= ST_DIV;
          else if (k_last) st <= ST_FIN;
          else             k  <= k + 1'b1;
        end
        ST_DIV: begin
          if (div_last) begin
            if (k_last) st <= ST_FIN;
            else begin
              st <= ST_LOAD;
              k  <= k + 1'b1;
            end
          end
        end
        default: begin
          st      <= ST_ACC;
          win_cnt <= '0;
        end
      endcase
    end
  end

  // ratio store
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < K_TOT; i++) ratio_q[i] <= '0;
      err_q <= '0;
    end else if (st == ST_LOAD) begin
      err_q[k] <= des_zero;
      if (des_zero) ratio_q[k] <= {RATIO_W{1'b1}};
    end else if ((st == ST_DIV) && div_last) begin
      ratio_q[k] <= quo_sat;
    end
  end

  for (genvar i = 0; i < K_TOT; i++) begin : g_flat
    assign ratio_flat[i*RATIO_W +: RATIO_W] = ratio_q[i];
  end

  tir_summer #(
    .P_NUM(P_NUM), .R_NUM(R_NUM), .RATIO_W(RATIO_W), .FRAC(FRAC),
    .PSUM_W(PSUM_W), .IDX_W(IDX_W)
  ) u_sum (
    .ratio_i (ratio_flat),
    .wgt_i   (wgt_i),
    .psum_o  (psum_c),
    .index_o (index_c)
  );

  // registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      ratio_o   <= '0;
      err_o     <= '0;
      psum_o    <= '0;
      index_o   <= '0;
      unclass_o <= '0;
    end else begin
      done_o <= clr;
      if (clr) begin
        ratio_o   <= ratio_flat;
        err_o     <= err_q;
        psum_o    <= psum_c;
        index_o   <= index_c;
        unclass_o <= ucnt_all;
      end
    end
  end
endmodule

// File: rtl/tir_eval_monitor_chk.sv
module tir_eval_monitor_chk #(
  parameter int P_NUM   = 2,
  parameter int R_NUM   = 3,
  parameter int RATIO_W = 16,
  parameter int PSUM_W  = 19,
  parameter int IDX_W   = 20
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           done_o,
  input logic [P_NUM*R_NUM*RATIO_W-1:0] ratio_o,
  input logic [P_NUM*R_NUM-1:0]         err_o,
  input logic [P_NUM*PSUM_W-1:0]        psum_o,
  input logic [IDX_W-1:0]               index_o
);
  logic [IDX_W-1:0] psum_total;

  always_comb begin
    psum_total = '0;
    for (int p = 0; p < P_NUM; p++) psum_total = psum_total + IDX_W'(psum_o[p*PSUM_W +: PSUM_W]);
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(ratio_o) && $stable(err_o) && $stable(psum_o) && $stable(index_o)));

  p_index_sum_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (index_o == psum_total));

  for (genvar k = 0; k < P_NUM*R_NUM; k++) begin : g_err
    p_err_sat_r6: assert property (@(posedge clk) disable iff (rst)
      err_o[k] |-> (ratio_o[k*RATIO_W +: RATIO_W] == {RATIO_W{1'b1}}));
  end
endmodule

bind tir_eval_monitor tir_eval_monitor_chk #(
  .P_NUM(P_NUM), .R_NUM(R_NUM), .RATIO_W(RATIO_W), .PSUM_W(PSUM_W), .IDX_W(IDX_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .done_o  (done_o),
  .ratio_o (ratio_o),
  .err_o   (err_o),
  .psum_o  (psum_o),
  .index_o (index_o)
);

// File: tb/tb_tir_eval_monitor.sv
module tb_tir_eval_monitor;
  localparam int P = 2, R = 3, VW = 8, CW = 16, WW = 9, RW = 16, PSW = 19, IXW = 20;
  localparam int K = P * R;

  logic clk = 1'b0, rst = 1'b1, smp = 1'b0;
  logic [P*VW-1:0]   vals = '0;
  logic [K*VW-1:0]   lo, hi;
  logic [CW-1:0]     win = '0;
  logic [K*CW-1:0]   des = '0;
  logic [K*WW-1:0]   wgt;
  logic              done;
  logic [K*RW-1:0]   ratio;
  logic [K-1:0]      err;
  logic [P*PSW-1:0]  psum;
  logic [IXW-1:0]    index;
  logic [P*CW-1:0]   unc;

  int checks = 0, errors = 0;
  int lo_a [K] = '{79, 74, 0, 200, 100, 0};
  int hi_a [K] = '{255, 78, 71, 255, 199, 120};
  int w_a  [K] = '{128, 64, 64, 100, 100, 56};
  int d_a  [K];
  int cnt_m [K];
  int unc_m [P];

  always #2 clk = ~clk;

  tir_eval_monitor dut (
    .clk(clk), .rst(rst), .smp_i(smp), .vals_i(vals), .lo_i(lo), .hi_i(hi),
    .win_len_i(win), .des_i(des), .wgt_i(wgt), .done_o(done), .ratio_o(ratio),
    .err_o(err), .psum_o(psum), .index_o(index), .unclass_o(unc));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_des(input int a0, a1, a2, a3, a4, a5);
    d_a = '{a0, a1, a2, a3, a4, a5};
    for (int k = 0; k < K; k++) des[k*CW +: CW] = CW'(d_a[k]);
  endtask

  task automatic clear_model();
    for (int k = 0; k < K; k++) cnt_m[k] = 0;
    for (int p = 0; p < P; p++) unc_m[p] = 0;
  endtask

  // one strobed sample; model follows R2/R3 priority rule
  task automatic send(input int t, input int f);
    int v [P];
    bit found;
    v = '{t, f};
    vals = {8'(f), 8'(t)};
    smp = 1'b1;
    for (int p = 0; p < P; p++) begin
      found = 0;
      for (int r = 0; r < R; r++)
        if (!found && v[p] >= lo_a[p*R+r] && v[p] <= hi_a[p*R+r]) begin
          cnt_m[p*R+r]++;
          found = 1;
        end
      if (!found) unc_m[p]++;
    end
    @(negedge clk);
    smp = 1'b0;
  endtask

  function automatic longint exp_ratio(int k);
    longint q;
    if (d_a[k] == 0) return 65535;
    q = (longint'(cnt_m[k]) * 256) / d_a[k];
    return (q > 65535) ? 65535 : q;
  endfunction

  // wait for done after closing sample; optionally strobe ignored samples (R10)
  task automatic finish_window(input string tag, input bit noise);
    int lat, exp_lat;
    longint acc, idx;
    exp_lat = 1;
    for (int k = 0; k < K; k++) exp_lat += (d_a[k] == 0) ? 1 : 25;
    lat = 0;
    if (noise) begin vals = {8'd250, 8'd90}; smp = 1'b1; end
    while (!done && lat < 2000) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    smp = 1'b0;
    chk({tag, " R9 latency"}, lat, exp_lat);
    idx = 0;
    for (int p = 0; p < P; p++) begin
      acc = 0;
      for (int r = 0; r < R; r++) begin
        chk({tag, " R5 ratio"}, ratio[(p*R+r)*RW +: RW], exp_ratio(p*R+r));
        chk({tag, " R6 err"}, err[p*R+r], d_a[p*R+r] == 0);
        acc += exp_ratio(p*R+r) * w_a[p*R+r];
      end
      chk({tag, " R7 score"}, psum[p*PSW +: PSW], acc >> 8);
      chk({tag, " R3 unclassified"}, unc[p*CW +: CW], unc_m[p]);
      idx += acc >> 8;
    end
    chk({tag, " R8 index"}, index, idx);
    @(negedge clk);
    chk({tag, " R9 pulse low"}, done, 0);
    clear_model();
  endtask

  initial begin
    for (int k = 0; k < K; k++) begin
      lo[k*VW +: VW] = VW'(lo_a[k]);
      hi[k*VW +: VW] = VW'(hi_a[k]);
      wgt[k*WW +: WW] = WW'(w_a[k]);
    end
    clear_model();
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 ratio", ratio, 0);
    chk("R1 index", index, 0);
    chk("R1 err", err, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {done, psum, unc}, 0);

    // W1: classification mix incl. overlap (110 -> range 1) and gap temps (R2, R3)
    win = 16'd10; set_des(3, 4, 2, 5, 3, 1);
    send(80, 210); send(75, 110); send(70, 50); send(73, 150); send(79, 255);
    send(74, 0);   send(78, 99);  send(72, 100); send(60, 200); send(100, 199);
    finish_window("W1 R2", 1'b1);

    // W2: zero desired counts; noise of W1 must not appear (R10, R6)
    win = 16'd4; set_des(0, 2, 0, 1, 1, 0);
    send(90, 10); send(90, 20); send(76, 30); send(73, 150);
    finish_window("W2 R10", 1'b0);

    // W3: window length 0 closes after one sample (R4)
    win = 16'd0; set_des(1, 1, 1, 1, 1, 1);
    send(73, 120);
    finish_window("W3 R4", 1'b0);

    // W4: quotient overflow saturates without error (R5)
    win = 16'd300; set_des(1, 1, 1, 1, 1, 1);
    for (int i = 0; i < 300; i++) send(90, 250);
    finish_window("W4 R5 sat", 1'b0);

    // W5: sweep of every value (R2, R3, R4)
    win = 16'd256; set_des(100, 10, 50, 60, 100, 90);
    for (int v = 0; v < 256; v++) send(v, 255 - v);
    finish_window("W5 R2 sweep", 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule